// File: doc/BRIEF.md
# Latched Multi-Channel Interrupt Controller

This block is a small programmable interrupt controller with a parameterized number of request inputs. Each input has its own 16-bit control register on a simple memory-mapped read/write bus. The register holds a priority level, an enable bit and a sticky request latch. Each input first passes through a two-flop synchronizer. A build-time mask then makes the channel either edge-sensitive (a rising edge sets the latch) or level-sensitive (a high line sets the latch).

The latch records events whether or not the channel is enabled, and it stays set after the source lets go of its line. There is no separate acknowledge. Software retires a request by writing the channel register with the detect qualifier set and the request bit zero. A write without that pattern changes the level and enable fields but never touches the latch, so masking and unmasking cannot lose an event. A level source that is still high when its latch is cleared sets the latch again at once.

The controller drives one interrupt line to the CPU. A read-only status register names the winning channel: the lowest level value among the enabled, latched channels, with the lowest channel number breaking ties.

Top module: `lintc_top`

## Requirements
- R1: After reset, every control register reads 0x0000, the status register reads 0x0000 and `irq_out` is low.
- R2: Channel i's control register sits at bus address i. Its fields are: level in bits [14:12], enable in bit 8, request latch (read-only) in bit 4, and detect qualifier in bit 0, which always reads 0. All other bits read 0. Every write to the register loads the level and enable fields from the write data. Without a write, neither field changes.
- R3: A channel's request latch is set by an input event even while its enable bit is 0. It stays set after the input returns low.
- R4: For a channel whose EDGE_MASK bit is 1, only a low-to-high transition of the synchronized input sets the latch. A line held high after the latch was cleared does not set it again.
- R5: For a channel whose EDGE_MASK bit is 0, the latch is set in every cycle that the synchronized input is high. A latch-clear write while the line is still high leaves the latch set.
- R6: A write with bit 0 = 1 and bit 4 = 0 clears the request latch. A write with bit 0 = 0, or with both bits 0 and 4 = 1, leaves the latch unchanged.
- R7: When an input event and a latch-clear write fall in the same cycle, the latch ends up set.
- R8: `irq_out` is high exactly when at least one channel is both enabled and latched.
- R9: The status register sits at bus address NCH. Bit 15 is high when some channel is enabled and latched. Bits [14:12] hold the winner's level and bits [IDX_W-1:0] hold the winner's index. The winner is the lowest level value, and on a tie the lowest channel number. The register reads 0x0000 when no channel qualifies, and writes to it have no effect.
- R10: An input change shows up in the latch no more than three clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_line | input | NCH | Asynchronous interrupt request lines, one per channel |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Register address: 0..NCH-1 for channels, NCH for status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
The bench clears a latch while the source is still active, on both an edge channel and a level channel. A design with one shared trigger rule would either fire twice on the edge channel or drop the level request. It also lines up a rising edge with a clear write in the same cycle; a design where the clear wins would lose that event. Writes that only enable or mask a channel, and writes carrying both qualifier and request bits, are checked to keep the latch, because a design that clears on any write would drop pending events. Random writes with many equal priority levels test the tie-break in the status register, where an arbiter that prefers the higher index or uses a non-strict compare would name the wrong channel.

// File: rtl/lintc_pkg.sv
package lintc_pkg;
  localparam int CR_W      = 16;
  localparam int LVL_W     = 3;
  localparam int LVL_LSB   = 12;
  localparam int EN_BIT    = 8;
  localparam int REQ_BIT   = 4;
  localparam int DET_BIT   = 0;
  localparam int VALID_BIT = 15;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic             en;
    logic             clr;
  } cr_wr_t;

  function automatic cr_wr_t decode_wr(input logic [CR_W-1:0] d);
    cr_wr_t r;
    r.lvl = d[LVL_LSB +: LVL_W];
    r.en  = d[EN_BIT];
    r.clr = d[DET_BIT] & ~d[REQ_BIT];
    return r;
  endfunction

  function automatic logic [CR_W-1:0] pack_cr(input logic [LVL_W-1:0] lvl,
                                                input logic en, input logic req);
    logic [CR_W-1:0] r;
    r = '0;
    r[LVL_LSB +: LVL_W] = lvl;
    r[EN_BIT]           = en;
    r[REQ_BIT]          = req;
    return r;
  endfunction
endpackage

// File: rtl/lintc_sync.sv
module lintc_sync #(
  parameter int              NCH       = 8,
  parameter logic [NCH-1:0]  EDGE_MASK = '0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] line_i,
  output logic [NCH-1:0] evt_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic s1_q, s2_q, s1_d, s2_d;

    always_comb begin
      s1_d = line_i[i];
      s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= s1_d;
        s2_q <= s2_d;
      end
    end

    if (EDGE_MASK[i]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= s2_q;
      end
      assign evt_o[i] = s2_q & ~prev_q;

      // R4
      edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o[i] |=> !evt_o[i]);
    end else begin : g_level
      assign evt_o[i] = s2_q;
    end
  end
endmodule

// File: rtl/lintc_chan.sv
module lintc_chan
  import lintc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  cr_wr_t           wr,
  input  logic             evt,
  output logic [LVL_W-1:0] lvl_o,
  output logic             en_o,
  output logic             req_o
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             en_q, en_d;
  logic             req_q, req_d;

  always_comb begin
    lvl_d = lvl_q;
    en_d  = en_q;
    req_d = req_q;
    if (wr_en) begin
      lvl_d = wr.lvl;
      en_d  = wr.en;
      if (wr.clr) req_d = 1'b0;
    end
    if (evt) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      en_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      en_q  <= en_d;
      req_q <= req_d;
    end
  end

  assign lvl_o = lvl_q;
  assign en_o  = en_q;
  assign req_o = req_q;

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !en_q) |=> req_q);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && wr_en && wr.clr) |=> req_q);
  // R6
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr.clr && !evt) |=> !req_q);
  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr.clr) && !evt) |=> $stable(req_q));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(lvl_q) && $stable(en_q)));
endmodule

// File: rtl/lintc_arb.sv
module lintc_arb
  import lintc_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            pend_i,
  input  logic [NCH-1:0][LVL_W-1:0] lvl_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [LVL_W-1:0]          lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pend_i[i] && (!valid_o || (lvl_i[i] < lvl_o))) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end

  // R9
  win_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (pend_i[idx_o] && (lvl_i[idx_o] == lvl_o)));
  // R9
  none_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (pend_i == '0));
endmodule

// File: rtl/lintc_top.sv
module lintc_top
  import lintc_pkg::*;
#(
  parameter int             NCH       = 8,
  parameter logic [NCH-1:0] EDGE_MASK = 8'h0F,
  parameter int             ADDR_W    = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    irq_line,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CR_W-1:0]   bus_wdata,
  output logic [CR_W-1:0]   bus_rdata,
  output logic              irq_out
);
  localparam int IDX_W = $clog2(NCH);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [NCH-1:0]            evt;
  logic [NCH-1:0]            wr_hit;
  logic [NCH-1:0]            en_v, req_v, pend;
  logic [NCH-1:0][LVL_W-1:0] lvl_v;
  cr_wr_t                    wr_dec;
  logic                      st_valid;
  logic [IDX_W-1:0]          st_idx;
  logic [LVL_W-1:0]          st_lvl;
  logic                      unused_wbits;

  assign wr_dec       = decode_wr(bus_wdata);
  assign unused_wbits = ^{bus_wdata[15], bus_wdata[11:9], bus_wdata[7:5], bus_wdata[3:1]};

  lintc_sync #(.NCH(NCH), .EDGE_MASK(EDGE_MASK)) sync_i (
    .clk(clk), .rst_n(rst_q), .line_i(irq_line), .evt_o(evt));

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign wr_hit[i] = bus_sel & bus_we & (bus_addr == ADDR_W'(i));
    lintc_chan chan_i (
      .clk(clk), .rst_n(rst_q), .wr_en(wr_hit[i]), .wr(wr_dec), .evt(evt[i]),
      .lvl_o(lvl_v[i]), .en_o(en_v[i]), .req_o(req_v[i]));
  end

  assign pend = en_v & req_v;

  lintc_arb #(.NCH(NCH), .IDX_W(IDX_W)) arb_i (
    .clk(clk), .rst_n(rst_q), .pend_i(pend), .lvl_i(lvl_v),
    .valid_o(st_valid), .idx_o(st_idx), .lvl_o(st_lvl));

  assign irq_out = |pend;

  logic [IDX_W-1:0] rd_idx;
  assign rd_idx = bus_addr[IDX_W-1:0];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr < ADDR_W'(NCH)) begin
        bus_rdata = pack_cr(lvl_v[rd_idx], en_v[rd_idx], req_v[rd_idx]);
      end else if (bus_addr == ADDR_W'(NCH)) begin
        bus_rdata[VALID_BIT]           = st_valid;
        bus_rdata[LVL_LSB +: LVL_W]    = st_lvl;
        bus_rdata[IDX_W-1:0]           = st_idx;
      end
    end
  end

  // R8
  irq_stat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq_out == st_valid);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> (!irq_out && (req_v == '0)));
endmodule

// File: tb/lintc_top_tb_top.sv
`timescale 1ns/1ps
module lintc_top_tb_top;
  localparam int NCH = 8;
  localparam int AW  = $clog2(NCH + 1);
  localparam logic [NCH-1:0] EMASK = 8'h0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] irq_line = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_out;

  always #2.5 clk = ~clk;

  lintc_top #(.NCH(NCH), .EDGE_MASK(EMASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  int checks = 0, errors = 0;
  logic [2:0] m_lvl [NCH];
  logic       m_en  [NCH];
  logic       m_req [NCH];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_cr(input int c);
    return {1'b0, m_lvl[c], 3'b0, m_en[c], 3'b0, m_req[c], 4'b0};
  endfunction

  function automatic logic [15:0] exp_stat();
    logic [15:0] r = '0;
    logic found = 1'b0;
    logic [2:0] bl = '0;
    for (int c = 0; c < NCH; c++)
      if (m_en[c] && m_req[c] && (!found || m_lvl[c] < bl)) begin
        found = 1'b1; bl = m_lvl[c];
        r = {1'b1, m_lvl[c], 12'(c)};
      end
    return r;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int c = 0; c < NCH; c++) r |= m_en[c] & m_req[c];
    return r;
  endfunction

  task automatic model_clear();
    for (int c = 0; c < NCH; c++) begin
      m_lvl[c] = '0; m_en[c] = 1'b0; m_req[c] = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_line = '0; bus_sel = 0; bus_we = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_clear();
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    if (a < NCH) begin
      m_lvl[a] = d[14:12];
      m_en[a]  = d[8];
      if (d[0] && !d[4]) m_req[a] = (!EMASK[a] && irq_line[a]);
    end
  endtask

  task automatic drive(input logic [NCH-1:0] v);
    for (int c = 0; c < NCH; c++) begin
      if (EMASK[c] && v[c] && !irq_line[c]) m_req[c] = 1'b1;
      if (!EMASK[c] && v[c]) m_req[c] = 1'b1;
    end
    irq_line = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [15:0] d;
    for (int c = 0; c < NCH; c++) begin
      rd(c, d);
      chk($sformatf("%s ch%0d", tag, c), d, exp_cr(c));
    end
    rd(NCH, d);
    chk({tag, " R9 status"}, d, exp_stat());
    chk({tag, " R8 irq_out"}, {15'b0, irq_out}, {15'b0, exp_irq()});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h1234_5678));
    do_reset();
    check_all("R1");

    // R2 full-ones write: detect and request both set, so no clear
    wr(2, 16'hFFFF);
    rd(2, d); chk("R2 layout", d, 16'h7100);

    // R3 capture on masked edge channel 1, then source drops
    irq_line[1] = 1'b1; m_req[1] = 1'b1;
    repeat (2) @(negedge clk);
    irq_line[1] = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R3");
    chk("R3 masked no irq", {15'b0, irq_out}, 16'h0);

    // R10 latency: rising edge seen within three edges
    irq_line[6] = 1'b1;
    repeat (3) @(posedge clk);
    #1 rd(6, d); chk("R10 latency", d & 16'h0010, 16'h0010);
    m_req[6] = 1'b1;

    // R6 enable-only write keeps latch; R8 irq then high
    wr(1, 16'h2100);
    check_all("R6 enable");
    chk("R8 irq high", {15'b0, irq_out}, 16'h1);
    wr(1, 16'h2111);
    check_all("R6 det+req");
    wr(1, 16'h2101);
    check_all("R6 clear");

    // R4 edge channel 0 held high after clear does not re-latch
    wr(0, 16'h0100);
    drive(irq_line | 8'h01);
    wr(0, 16'h0101);
    repeat (4) @(negedge clk);
    check_all("R4 edge held");
    rd(0, d); chk("R4 no relatch", d & 16'h0010, 16'h0000);

    // R5 level channel 5 cleared while high stays set, then clears once low
    wr(5, 16'h3100);
    drive(irq_line | 8'h20);
    wr(5, 16'h3101);
    check_all("R5 relatch");
    drive(irq_line & ~8'h20);
    wr(5, 16'h3101);
    check_all("R5 low clear");

    // R7 rising edge on channel 3 coincides with clear write
    irq_line[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(3, 16'h1101);
    m_req[3] = 1'b1;
    check_all("R7 set wins");

    // R9 tie at equal levels, write to status ignored
    wr(4, 16'h1100); wr(7, 16'h1100);
    drive(irq_line | 8'h90);
    check_all("R9 tie");
    wr(NCH, 16'hFFFF);
    check_all("R9 status write");

    // random phase
    do_reset();
    check_all("R1 again");
    for (int it = 0; it < 400; it++) begin
      int k = $urandom_range(0, 9);
      if (k < 3) begin
        drive(NCH'($urandom));
      end else begin
        logic [15:0] rd_data = 16'($urandom);
        if ($urandom_range(0, 1)) rd_data[2:0] = 3'($urandom_range(0, 1));
        rd_data[14:12] = 3'($urandom_range(0, 2));
        wr($urandom_range(0, NCH), rd_data);
      end
      check_all("R2/R6/R9 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule